// File: doc/BRIEF.md
# Masked vector compress unit

This unit gathers the selected 64-bit lanes of a source vector and packs them, in their original order, into a contiguous run that starts at the lowest lane. A per-lane mask chooses the lanes. A length code sets the active vector width to 2, 4 or 8 lanes. Lanes at or above that width never take part.

The unit has two modes. In register mode it returns a full 512-bit result. Lanes above the packed run but inside the active width are either copied from the old destination value (merge) or zeroed. Everything above the active width is cleared. In store mode it returns the packed data together with per-byte write enables that cover only the packed lanes. A store request with zeroing is an illegal encoding and is flagged.

Operands are captured on a valid strobe. The result, byte enables, packed count and illegal flag are registered and appear one clock later, with a single-cycle output valid pulse. Between pulses the outputs hold their values.

Top module: `vcmp_unit`

## Requirements
- R1: `len_sel` selects the active lane count: code 0 gives 2 lanes, code 1 gives 4 lanes, code 2 gives 8 lanes, and code 3 is treated as 8 lanes.
- R2: With `mask_en`=1, the lanes whose mask bit is 1 are taken from lane 0 upward. The k-th taken lane appears in result lane k (bits 64k+63..64k), so the source order is kept.
- R3: With `mask_en`=0, every lane inside the active width is taken, and the result lanes inside the active width equal the source lanes.
- R4: In register mode (`store_mode`=0) with `zero_en`=0, result lanes from the packed count up to the active width carry the matching lanes of `old_vec`.
- R5: In register mode with `zero_en`=1, result lanes from the packed count up to the active width are zero.
- R6: In register mode, every result bit above the active width, up to bit 511, is zero, whatever the value of `zero_en`.
- R7: In store mode with `zero_en`=0, `byte_en` bits 0 to 8×count−1 are 1 and all other bits are 0, and result lanes at or above the count are zero. In register mode, `byte_en` is all zero.
- R8: `store_mode`=1 together with `zero_en`=1 sets `illegal` and forces `byte_en` to zero. Every other combination clears `illegal`.
- R9: Mask bits at or above the active lane count have no effect on the count, the result or the byte enables.
- R10: `packed_cnt` (0 to 8) equals the number of lanes taken. An all-zero mask with `mask_en`=1 gives a count of 0 and no byte enables.
- R11: The outputs update on the clock edge that samples `in_valid`=1. `out_valid` is 1 for exactly that one following cycle. The outputs hold their values while `in_valid` is 0. Reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the operands |
| src_vec | input | 512 | Source lanes, lane j in bits 64j+63..64j |
| old_vec | input | 512 | Previous destination value, used for merge |
| mask | input | 8 | Lane select, bit j for lane j |
| mask_en | input | 1 | 1: use `mask`; 0: take all lanes |
| zero_en | input | 1 | 1: zero fill above the packed run |
| store_mode | input | 1 | 0: register mode; 1: store mode |
| len_sel | input | 2 | Active width code (see R1) |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 512 | Packed vector |
| byte_en | output | 64 | Store byte enables, bit b for byte b |
| packed_cnt | output | 4 | Number of packed lanes |
| illegal | output | 1 | Store with zeroing was requested |

## Verification
Two behaviours can act on the same result in one cycle. The merge or zero fill above the packed run can coincide with the clearing of lanes above a 2- or 4-lane active width. This is provoked by an exhaustive sweep over every length code, all 256 masks, and both settings of `mask_en`, `zero_en` and `store_mode`. Every lane of `old_vec` is non-zero, so a lost merge and a lost clear each show up as a wrong lane value. Each lane is judged separately against a bench model and tagged by the region it falls in: packed, filled, or above the width. Store with zeroing is swept in the same pass, so the illegal flag and the suppressed enables are judged together with the count.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  // width of the active-length code
  localparam int unsigned LSEL_W = 2;

  typedef enum logic {
    MODE_REG   = 1'b0,
    MODE_STORE = 1'b1
  } vcmp_mode_e;

  // active lane count for a length code, bounded by the lane capacity
  function automatic int unsigned vl_lanes(input logic [LSEL_W-1:0] code,
                                           input int unsigned max_lanes);
    int unsigned n;
    n = 2 << code;
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

endpackage

// File: rtl/vcmp_vl_decode.sv
module vcmp_vl_decode
  import vcmp_pkg::*;
#(
  parameter int unsigned MAX_LANES = 8
) (
  input  logic [LSEL_W-1:0]    len_sel,
  output logic [MAX_LANES-1:0] lane_en
);

  int unsigned lanes;

  always_comb begin
    lanes = vl_lanes(len_sel, MAX_LANES);
  end

  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    assign lane_en[l] = (l < lanes);
  end

endmodule

// File: rtl/vcmp_pack.sv
module vcmp_pack #(
  parameter int unsigned LANE_W    = 64,
  parameter int unsigned MAX_LANES = 8,
  parameter int unsigned CNT_W     = 4
) (
  input  logic [LANE_W*MAX_LANES-1:0] src,
  input  logic [MAX_LANES-1:0]        act,
  output logic [LANE_W*MAX_LANES-1:0] packed_vec,
  output logic [CNT_W-1:0]            cnt
);

  // destination slot of each source lane = number of active lanes below it
  logic [CNT_W-1:0] slot [MAX_LANES];

  always_comb begin
    slot[0] = '0;
    for (int j = 1; j < MAX_LANES; j++) begin
      slot[j] = slot[j-1] + CNT_W'(act[j-1]);
    end
    cnt = slot[MAX_LANES-1] + CNT_W'(act[MAX_LANES-1]);
  end

  for (genvar d = 0; d < MAX_LANES; d++) begin : g_dst
    logic [LANE_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int j = d; j < MAX_LANES; j++) begin
        if (act[j] && (slot[j] == CNT_W'(d))) pick = pick | src[j*LANE_W +: LANE_W];
      end
    end
    assign packed_vec[d*LANE_W +: LANE_W] = pick;
  end

endmodule

// File: rtl/vcmp_fill.sv
module vcmp_fill
  import vcmp_pkg::*;
#(
  parameter int unsigned LANE_W    = 64,
  parameter int unsigned MAX_LANES = 8,
  parameter int unsigned CNT_W     = 4
) (
  input  logic [LANE_W*MAX_LANES-1:0]     packed_vec,
  input  logic [LANE_W*MAX_LANES-1:0]     old_vec,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [MAX_LANES-1:0]            lane_en,
  input  logic                            zero_en,
  input  vcmp_mode_e                      mode,
  output logic [LANE_W*MAX_LANES-1:0]     result,
  output logic [LANE_W*MAX_LANES/8-1:0]   byte_en,
  output logic                            illegal
);

  localparam int unsigned LANE_B = LANE_W / 8;

  logic store_ok;

  assign illegal  = (mode == MODE_STORE) && zero_en;
  assign store_ok = (mode == MODE_STORE) && !zero_en;

  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    logic in_run;
    logic [LANE_W-1:0] lane_val;

    assign in_run = (CNT_W'(l) < cnt);

    always_comb begin
      if (!lane_en[l])                lane_val = '0;
      else if (in_run)                lane_val = packed_vec[l*LANE_W +: LANE_W];
      else if (mode == MODE_STORE)    lane_val = '0;
      else if (zero_en)               lane_val = '0;
      else                            lane_val = old_vec[l*LANE_W +: LANE_W];
    end

    assign result[l*LANE_W +: LANE_W]  = lane_val;
    assign byte_en[l*LANE_B +: LANE_B] = {LANE_B{store_ok && in_run && lane_en[l]}};
  end

endmodule

// File: rtl/vcmp_unit.sv
module vcmp_unit
  import vcmp_pkg::*;
#(
  parameter int unsigned LANE_W    = 64,
  parameter int unsigned MAX_LANES = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [LANE_W*MAX_LANES-1:0]       src_vec,
  input  logic [LANE_W*MAX_LANES-1:0]       old_vec,
  input  logic [MAX_LANES-1:0]              mask,
  input  logic                              mask_en,
  input  logic                              zero_en,
  input  logic                              store_mode,
  input  logic [LSEL_W-1:0]                 len_sel,
  output logic                              out_valid,
  output logic [LANE_W*MAX_LANES-1:0]       result,
  output logic [LANE_W*MAX_LANES/8-1:0]     byte_en,
  output logic [$clog2(MAX_LANES+1)-1:0]    packed_cnt,
  output logic                              illegal
);

  localparam int unsigned VEC_W  = LANE_W * MAX_LANES;
  localparam int unsigned BYTE_W = VEC_W / 8;
  localparam int unsigned CNT_W  = $clog2(MAX_LANES + 1);

  // ---------------- reset synchronizer (async assert, sync release)
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // ---------------- combinational datapath
  logic [MAX_LANES-1:0] lane_en;
  logic [MAX_LANES-1:0] act;
  logic [VEC_W-1:0]     packed_vec;
  logic [CNT_W-1:0]     cnt_c;
  logic [VEC_W-1:0]     result_c;
  logic [BYTE_W-1:0]    byte_en_c;
  logic                 illegal_c;
  vcmp_mode_e           mode;

  assign mode = vcmp_mode_e'(store_mode);
  assign act  = mask_en ? (mask & lane_en) : lane_en;

  vcmp_vl_decode #(.MAX_LANES(MAX_LANES)) u_dec (
    .len_sel (len_sel),
    .lane_en (lane_en)
  );

  vcmp_pack #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .CNT_W(CNT_W)) u_pack (
    .src        (src_vec),
    .act        (act),
    .packed_vec (packed_vec),
    .cnt        (cnt_c)
  );

  vcmp_fill #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .CNT_W(CNT_W)) u_fill (
    .packed_vec (packed_vec),
    .old_vec    (old_vec),
    .cnt        (cnt_c),
    .lane_en    (lane_en),
    .zero_en    (zero_en),
    .mode       (mode),
    .result     (result_c),
    .byte_en    (byte_en_c),
    .illegal    (illegal_c)
  );

  // ---------------- next state
  logic                 vld_d, vld_q;
  logic [VEC_W-1:0]     res_d, res_q;
  logic [BYTE_W-1:0]    be_d, be_q;
  logic [CNT_W-1:0]     cnt_d, cnt_q;
  logic                 ill_d, ill_q;
  logic                 st_d, st_q;
  logic [MAX_LANES-1:0] len_d, len_q;

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    be_d  = be_q;
    cnt_d = cnt_q;
    ill_d = ill_q;
    st_d  = st_q;
    len_d = len_q;
    if (in_valid) begin
      res_d = result_c;
      be_d  = byte_en_c;
      cnt_d = cnt_c;
      ill_d = illegal_c;
      st_d  = store_mode;
      len_d = lane_en;
    end
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    res_q <= res_d;
    be_q  <= be_d;
    cnt_q <= cnt_d;
    ill_q <= ill_d;
    st_q  <= st_d;
    len_q <= len_d;
  end

  assign out_valid  = vld_q;
  assign result     = res_q;
  assign byte_en    = be_q;
  assign packed_cnt = cnt_q;
  assign illegal    = ill_q;

  // ---------------- assertions
  logic [VEC_W-1:0] width_bits_q;
  for (genvar l = 0; l < MAX_LANES; l++) begin : g_wb
    assign width_bits_q[l*LANE_W +: LANE_W] = {LANE_W{len_q[l]}};
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  // R8
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && illegal) |-> (byte_en == '0));

  // R7
  store_bytes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && st_q && !illegal) |-> ($countones(byte_en) == int'(packed_cnt) * (LANE_W / 8)));

  // R7
  reg_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !st_q) |-> (byte_en == '0));

  // R6
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !st_q) |-> ((result & ~width_bits_q) == '0));

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (int'(packed_cnt) <= $countones(len_q)));

endmodule

// File: tb/sim_vcmp_unit.sv
module sim_vcmp_unit;

  localparam int LW = 64;
  localparam int NL = 8;
  localparam int VW = LW * NL;
  localparam int BW = VW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [VW-1:0] src_vec, old_vec;
  logic [NL-1:0] mask;
  logic          mask_en, zero_en, store_mode;
  logic [1:0]    len_sel;
  logic          out_valid;
  logic [VW-1:0] result;
  logic [BW-1:0] byte_en;
  logic [3:0]    packed_cnt;
  logic          illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vcmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_vec(src_vec), .old_vec(old_vec), .mask(mask),
    .mask_en(mask_en), .zero_en(zero_en), .store_mode(store_mode),
    .len_sel(len_sel), .out_valid(out_valid), .result(result),
    .byte_en(byte_en), .packed_cnt(packed_cnt), .illegal(illegal)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired: actual %0d expected %0d", 1, 0);
    report();
  end

  // reference: lanes 2/4/8 for codes 0/1/2, 8 for code 3
  function automatic int ref_lanes(input logic [1:0] ls);
    return (ls == 2'd0) ? 2 : (ls == 2'd1) ? 4 : 8;
  endfunction

  logic [VW-1:0] exp_res;
  logic [BW-1:0] exp_be;
  int            exp_cnt;
  bit            exp_ill;

  task automatic model();
    int nl;
    nl = ref_lanes(len_sel);
    exp_res = '0;
    exp_cnt = 0;
    for (int j = 0; j < nl; j++) begin
      if (!mask_en || mask[j]) begin
        exp_res[exp_cnt*LW +: LW] = src_vec[j*LW +: LW];
        exp_cnt++;
      end
    end
    if (!store_mode) begin
      for (int k = exp_cnt; k < nl; k++)
        exp_res[k*LW +: LW] = zero_en ? '0 : old_vec[k*LW +: LW];
    end
    exp_ill = store_mode && zero_en;
    exp_be  = '0;
    if (store_mode && !zero_en)
      for (int b = 0; b < exp_cnt*8; b++) exp_be[b] = 1'b1;
  endtask

  task automatic run_op(input int it);
    int nl;
    bit upper;
    string rq;
    @(negedge clk);
    for (int j = 0; j < NL; j++) begin
      src_vec[j*LW +: LW] = 64'h5A00_0000_0000_0000 | (64'(j + 1) << 40) | 64'(it);
      old_vec[j*LW +: LW] = 64'hC300_0000_0000_0000 | (64'(j + 1) << 32) | 64'(it * 3 + 1);
    end
    in_valid = 1'b1;
    model();
    nl = ref_lanes(len_sel);
    upper = mask_en && ((mask >> nl) != 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R11", "out_valid after capture", VW'(out_valid), VW'(1));
    // R10 count, R1 width when unmasked, R9 masks with bits above width
    rq = upper ? "R9" : (!mask_en ? "R1" : "R10");
    chk(packed_cnt === 4'(exp_cnt), rq, "packed_cnt", VW'(packed_cnt), VW'(exp_cnt));
    chk(illegal === exp_ill, "R8", "illegal", VW'(illegal), VW'(exp_ill));
    chk(byte_en === exp_be, exp_ill ? "R8" : "R7", "byte_en", VW'(byte_en), VW'(exp_be));
    for (int k = 0; k < NL; k++) begin
      if (k < exp_cnt)      rq = mask_en ? (upper ? "R9" : "R2") : "R3";
      else if (k >= nl)     rq = store_mode ? "R7" : "R6";
      else if (store_mode)  rq = "R7";
      else                  rq = zero_en ? "R5" : "R4";
      chk(result[k*LW +: LW] === exp_res[k*LW +: LW], rq, $sformatf("result lane %0d", k),
          VW'(result[k*LW +: LW]), VW'(exp_res[k*LW +: LW]));
    end
    @(negedge clk);
    chk(out_valid === 1'b0, "R11", "out_valid one cycle", VW'(out_valid), VW'(0));
    chk(result === exp_res, "R11", "result hold", result, exp_res);
  endtask

  initial begin
    int it;
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '0; old_vec = '0; mask = '0;
    mask_en = 1'b0; zero_en = 1'b0; store_mode = 1'b0; len_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11", "out_valid in reset", VW'(out_valid), VW'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0, "R11", "out_valid after reset", VW'(out_valid), VW'(0));
    it = 0;
    for (int ls = 0; ls < 4; ls++)
      for (int md = 0; md < 8; md++)
        for (int m = 0; m < 256; m++) begin
          if ((md & 1) == 0 && m > 0) continue; // mask ignored when unmasked: one pass
          len_sel    = 2'(ls);
          mask_en    = md[0];
          zero_en    = md[1];
          store_mode = md[2];
          mask       = 8'(m);
          run_op(it);
          it++;
        end
    // R10 explicit: empty mask in store mode gives no enables
    len_sel = 2'd2; mask_en = 1'b1; zero_en = 1'b0; store_mode = 1'b1; mask = 8'h00;
    run_op(it);
    chk(byte_en === '0, "R10", "empty mask enables", VW'(byte_en), VW'(0));
    report();
  end

endmodule